// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable ratio N built from three cooperating counters. A dual-modulus prescaler counts either 16 or 17 input clocks per period. A swallow counter decides for how many prescaler periods of each output cycle the prescaler runs in its divide-by-17 mode. A main counter sets how many prescaler periods make up one output cycle. With a main value M and a swallow value A, one output cycle lasts N = 16*M + A input clocks. The divided output is a single-clock pulse intended for a phase comparator. The modulus-select line is brought out, and a half-rate test output is available.

The ratio word comes from a control register and may be rewritten at any time. The block samples it only at an output-cycle boundary, so the cycle in progress always finishes with the ratio it started with. A ratio that cannot be built by this structure (swallow value above the main value, or a main value of zero) is clamped to the nearest buildable ratio, and a flag output marks the cycles that run on a clamped ratio.

Top module: `psw_divider`

## Requirements
- R1: While `rst` is high, every clock edge leaves `div_o` at 0, `test_o` at 0, `clamp_o` at 0 and `mod_o` at 1 (1 selects divide-by-17, 0 selects divide-by-16).
- R2: For a buildable ratio, `div_o` pulses once every N = 16*M + A clocks. The first pulse follows the edge that comes N clocks after the first edge at which `rst` is low.
- R3: Each `div_o` pulse is exactly one clock wide.
- R4: Within each output cycle, `mod_o` is 1 for the first A prescaler periods (17*A clocks) and 0 for the rest. It changes only at a prescaler period boundary.
- R5: The swallow value A is taken from `ratio_i[3:0]` and the main value M from `ratio_i[14:4]`.
- R6: `ratio_i` is sampled only at the clock edge that raises `div_o` (and at the first edge after reset). A change made during a cycle takes effect from the following cycle.
- R7: If A > M and M > 0, the block runs with A replaced by M, so N = 17*M, and it raises `clamp_o` for those cycles.
- R8: If M = 0, the block runs with M = 1 and A = min(A, 1), and it raises `clamp_o` for those cycles.
- R9: While `test_en` is high, `test_o` toggles at the same edge that raises `div_o`. While `test_en` is low, `test_o` is held at 0.
- R10: `clamp_o` is 0 during cycles that run on a buildable ratio (M ≥ 1 and A ≤ M).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| ratio_i | input | 15 | Ratio word: main value in [14:4], swallow value in [3:0] |
| test_en | input | 1 | Enables the half-rate test output |
| div_o | output | 1 | One-clock pulse at the end of each output cycle |
| mod_o | output | 1 | Prescaler modulus select: 1 = divide-by-17, 0 = divide-by-16 |
| test_o | output | 1 | Divided output halved in frequency |
| clamp_o | output | 1 | The current cycle runs on a clamped ratio |

## Verification
The bench builds the block with its default widths: a 4-bit swallow field and an 11-bit main field. It keeps the main value small so that each output cycle stays short. At these widths every swallow value from 0 to the field maximum of 15 can be reached. This lets the bench cover the edges of the swallow range: no swallowing at all, swallowing on every prescaler period (A = M), and A = 15 with a main value of 20. It also covers the clamped regions A > M and M = 0, and a main value of 100 for a cycle well over a thousand clocks long.

// File: rtl/psw_pkg.sv
`timescale 1ns/1ps
package psw_pkg;
  // Prescaler modulus selection
  typedef enum logic {
    MOD_DIV_LO = 1'b0,   // divide by 2**SW_W
    MOD_DIV_HI = 1'b1    // divide by 2**SW_W + 1
  } mod_sel_e;

  localparam int unsigned SWALLOW_W_DEF = 4;
  localparam int unsigned MAIN_W_DEF    = 11;
endpackage

// File: rtl/psw_prescaler.sv
`timescale 1ns/1ps
// Dual-modulus prescaler modelled as a counter: one terminal pulse every
// 2**SW_W or 2**SW_W+1 input clocks depending on mod_sel.
module psw_prescaler
  import psw_pkg::*;
#(
  parameter int unsigned SW_W = SWALLOW_W_DEF
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     run,
  input  mod_sel_e mod_sel,
  output logic     tc
);
  localparam int unsigned CW = SW_W + 1;
  localparam logic [CW-1:0] LAST_LO = CW'((2 ** SW_W) - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(2 ** SW_W);

  logic [CW-1:0] cnt_q;

  assign tc = run && (cnt_q == ((mod_sel == MOD_DIV_HI) ? LAST_HI : LAST_LO));

  always_ff @(posedge clk) begin
    if (rst || !run || tc) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/psw_ratio_reg.sv
`timescale 1ns/1ps
// Holds the ratio of the cycle in progress; repairs unbuildable words.
module psw_ratio_reg #(
  parameter int unsigned SW_W = 4,
  parameter int unsigned MN_W = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [SW_W+MN_W-1:0] ratio_i,
  output logic [SW_W-1:0]      a_next,
  output logic [SW_W-1:0]      a_act,
  output logic [MN_W-1:0]      m_act,
  output logic                 clamp_act
);
  logic [SW_W-1:0] a_raw;
  logic [MN_W-1:0] m_raw;
  logic [MN_W-1:0] m_fix;
  logic [MN_W-1:0] a_wide;
  logic            a_over;
  logic            clamp_next;

  always_comb begin
    a_raw      = ratio_i[SW_W-1:0];
    m_raw      = ratio_i[SW_W +: MN_W];
    m_fix      = (m_raw == '0) ? MN_W'(1) : m_raw;
    a_wide     = MN_W'(a_raw);
    a_over     = (a_wide > m_fix);
    a_next     = a_over ? SW_W'(m_fix) : a_raw;
    clamp_next = (m_raw == '0) || a_over;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_act     <= '0;
      m_act     <= MN_W'(1);
      clamp_act <= 1'b0;
    end else if (load) begin
      a_act     <= a_next;
      m_act     <= m_fix;
      clamp_act <= clamp_next;
    end
  end
endmodule

// File: rtl/psw_swallow_ctl.sv
`timescale 1ns/1ps
// Swallow and main counters; drive the prescaler modulus.
module psw_swallow_ctl
  import psw_pkg::*;
#(
  parameter int unsigned SW_W = 4,
  parameter int unsigned MN_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tc,
  input  logic [SW_W-1:0] a_act,
  input  logic [SW_W-1:0] a_next,
  input  logic [MN_W-1:0] m_act,
  output logic            run,
  output mod_sel_e        mod_sel,
  output logic            last,
  output logic            load
);
  logic [SW_W-1:0] a_cnt_q;
  logic [MN_W-1:0] m_cnt_q;
  logic [SW_W-1:0] a_inc;

  assign a_inc = a_cnt_q + 1'b1;
  assign last  = tc && (m_cnt_q == (m_act - 1'b1));
  assign load  = !run || last;

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      a_cnt_q <= '0;
      m_cnt_q <= '0;
      mod_sel <= MOD_DIV_HI;
    end else if (load) begin
      run     <= 1'b1;
      a_cnt_q <= '0;
      m_cnt_q <= '0;
      mod_sel <= (a_next != '0) ? MOD_DIV_HI : MOD_DIV_LO;
    end else if (tc) begin
      m_cnt_q <= m_cnt_q + 1'b1;
      if (mod_sel == MOD_DIV_HI) begin
        a_cnt_q <= a_inc;
        mod_sel <= (a_inc < a_act) ? MOD_DIV_HI : MOD_DIV_LO;
      end
    end
  end
endmodule

// File: rtl/psw_divider.sv
`timescale 1ns/1ps
module psw_divider
  import psw_pkg::*;
#(
  parameter int unsigned SW_W = SWALLOW_W_DEF,
  parameter int unsigned MN_W = MAIN_W_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SW_W+MN_W-1:0] ratio_i,
  input  logic                 test_en,
  output logic                 div_o,
  output logic                 mod_o,
  output logic                 test_o,
  output logic                 clamp_o
);
  logic            run;
  logic            pre_tc;
  logic            last;
  logic            load;
  mod_sel_e        mod_sel;
  logic [SW_W-1:0] a_next;
  logic [SW_W-1:0] a_act;
  logic [MN_W-1:0] m_act;
  logic            clamp_act;
  logic            div_q;
  logic            tog_q;

  psw_prescaler #(.SW_W(SW_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .mod_sel (mod_sel),
    .tc      (pre_tc)
  );

  psw_ratio_reg #(.SW_W(SW_W), .MN_W(MN_W)) u_ratio (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .ratio_i   (ratio_i),
    .a_next    (a_next),
    .a_act     (a_act),
    .m_act     (m_act),
    .clamp_act (clamp_act)
  );

  psw_swallow_ctl #(.SW_W(SW_W), .MN_W(MN_W)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .tc      (pre_tc),
    .a_act   (a_act),
    .a_next  (a_next),
    .m_act   (m_act),
    .run     (run),
    .mod_sel (mod_sel),
    .last    (last),
    .load    (load)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      div_q <= last;
      if (!test_en) begin
        tog_q <= 1'b0;
      end else if (last) begin
        tog_q <= ~tog_q;
      end
    end
  end

  assign div_o   = div_q;
  assign test_o  = tog_q;
  assign mod_o   = (mod_sel == MOD_DIV_HI);
  assign clamp_o = clamp_act;
endmodule

// File: rtl/psw_divider_chk.sv
`timescale 1ns/1ps
module psw_divider_chk (
  input logic clk,
  input logic rst,
  input logic run,
  input logic pre_tc,
  input logic test_en,
  input logic div_o,
  input logic mod_o,
  input logic test_o,
  input logic clamp_o
);
  // R1: reset drives the documented idle values
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (mod_o && !div_o && !test_o && !clamp_o));

  // R3: pulse lasts a single clock
  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (rst)
    div_o |=> !div_o);

  // R2: a pulse only follows a prescaler terminal count
  assert_pulse_on_tc_R2: assert property (@(posedge clk) disable iff (rst)
    div_o |-> $past(pre_tc));

  // R4: modulus select moves only at prescaler boundaries
  assert_mod_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (run && !pre_tc) |=> $stable(mod_o));

  // R9: test output toggles with every pulse when enabled
  assert_test_toggle_R9: assert property (@(posedge clk) disable iff (rst)
    (div_o && $past(test_en)) |-> (test_o != $past(test_o)));

  // R9: test output held low when disabled
  assert_test_off_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!test_en) |-> !test_o);
endmodule

bind psw_divider psw_divider_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .run     (run),
  .pre_tc  (pre_tc),
  .test_en (test_en),
  .div_o   (div_o),
  .mod_o   (mod_o),
  .test_o  (test_o),
  .clamp_o (clamp_o)
);

// File: tb/psw_divider_tb_top.sv
`timescale 1ns/1ps
module psw_divider_tb_top;
  localparam int SW_W  = 4;
  localparam int MN_W  = 11;
  localparam int LIMIT = 5000;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 test_en = 1'b0;
  logic [SW_W+MN_W-1:0] ratio = '0;
  logic                 div_o;
  logic                 mod_o;
  logic                 test_o;
  logic                 clamp_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  psw_divider #(.SW_W(SW_W), .MN_W(MN_W)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .ratio_i (ratio),
    .test_en (test_en),
    .div_o   (div_o),
    .mod_o   (mod_o),
    .test_o  (test_o),
    .clamp_o (clamp_o)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R5: main value in [14:4], swallow value in [3:0]
  task automatic set_ratio(int m, int a);
    ratio = {MN_W'(m), SW_W'(a)};
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!div_o && n < LIMIT);
  endtask

  // Called at a pulse negedge; runs to the next pulse negedge.
  task automatic measure(output int len, output int modc, output int width_hi);
    modc = mod_o ? 1 : 0;
    len = 0;
    width_hi = 0;
    forever begin
      @(negedge clk);
      len++;
      if (len == 1 && div_o) width_hi = 1;
      if ((div_o && len > 1) || len >= LIMIT) break;
      modc += mod_o ? 1 : 0;
    end
  endtask

  task automatic t_reset_first;
    int n;
    rst = 1'b1;
    set_ratio(3, 2);
    repeat (3) @(negedge clk);
    check_eq("R1", "div_o in reset", int'(div_o), 0);
    check_eq("R1", "mod_o in reset", int'(mod_o), 1);
    check_eq("R1", "test_o in reset", int'(test_o), 0);
    check_eq("R1", "clamp_o in reset", int'(clamp_o), 0);
    rst = 1'b0;
    wait_pulse(n);
    check_eq("R2", "first pulse delay", n, 16 * 3 + 2 + 1);
    check_eq("R10", "clamp_o valid ratio", int'(clamp_o), 0);
  endtask

  task automatic t_period(int m, int a);
    int n, len, modc, w;
    set_ratio(m, a);
    wait_pulse(n);
    check_eq("R10", "clamp_o valid ratio", int'(clamp_o), 0);
    measure(len, modc, w);
    check_eq("R2", $sformatf("period M=%0d A=%0d", m, a), len, 16 * m + a);
    check_eq("R4", $sformatf("div17 clocks M=%0d A=%0d", m, a), modc, 17 * a);
    check_eq("R3", "pulse width", w, 0);
  endtask

  task automatic t_reload;
    int n, len, modc, w;
    set_ratio(4, 3);
    wait_pulse(n);
    set_ratio(2, 1);
    measure(len, modc, w);
    check_eq("R6", "cycle keeps old ratio", len, 67);
    measure(len, modc, w);
    check_eq("R6", "next cycle uses new ratio", len, 33);
  endtask

  task automatic t_clamp(string req, int m, int a, int me, int ae);
    int n, len, modc, w;
    set_ratio(m, a);
    wait_pulse(n);
    check_eq(req, $sformatf("clamp_o M=%0d A=%0d", m, a), int'(clamp_o), 1);
    measure(len, modc, w);
    check_eq(req, $sformatf("clamped period M=%0d A=%0d", m, a), len, 16 * me + ae);
    check_eq(req, $sformatf("clamped div17 M=%0d A=%0d", m, a), modc, 17 * ae);
  endtask

  task automatic t_test_out;
    int n, len, modc, w, t0, t1, t2, ones;
    test_en = 1'b1;
    set_ratio(1, 1);
    wait_pulse(n);
    wait_pulse(n);
    t0 = int'(test_o);
    measure(len, modc, w);
    t1 = int'(test_o);
    measure(len, modc, w);
    t2 = int'(test_o);
    check_eq("R9", "toggle on pulse 1", t1, 1 - t0);
    check_eq("R9", "toggle on pulse 2", t2, 1 - t1);
    test_en = 1'b0;
    ones = 0;
    repeat (60) begin
      @(negedge clk);
      ones += test_o ? 1 : 0;
    end
    check_eq("R9", "test_o while disabled", ones, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_first();
    t_period(3, 2);
    t_period(4, 0);
    t_period(5, 5);
    t_period(1, 0);
    t_period(1, 1);
    t_period(20, 15);
    t_period(100, 7);
    t_reload();
    t_clamp("R7", 2, 5, 2, 2);
    t_clamp("R8", 0, 0, 1, 0);
    t_clamp("R8", 0, 3, 1, 1);
    t_period(6, 4);
    t_test_out();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule